// File: doc/BRIEF.md
# Posted-Column Data Latency Sequencer

This block sits beside the command path of a double-data-rate memory controller. Each controller clock it may take at most one column command: a read or a write with a start column. It works out in which later clock cycles the data for that command moves on the bus, and marks them with per-cycle window flags. Each flag comes with the clock index inside the burst and the two column offsets carried in that clock.

The read delay is the sum of an additive part (0 to 4 clocks), which allows posted column commands, and a column-access part (3, 4 or 5 clocks). The write delay is always one clock shorter than the read delay. A burst lasts 2 or 4 clocks, for bursts of 4 or 8 beats. Beats follow either a sequential or an interleaved column order, seeded by the low start-column bits. Configuration is loaded through a small write port and is taken only while the block is idle. Commands that come too close together are flagged and dropped. Every outstanding burst has its own slot, which holds its direction, its start column and its age.

Top module: `cas_lat_seq`

## Requirements
- R1: While reset is held and after it is released, rd_valid, wr_valid and proto_err are 0. Out of reset the configuration is column latency 3, additive latency 0, 4-beat bursts and sequential order.
- R2: A read accepted at clock edge E raises rd_valid after edge E+AL+CL, for burst-length/2 consecutive clocks.
- R3: A write accepted at edge E raises wr_valid after edge E+AL+CL-1, for burst-length/2 consecutive clocks. rd_valid stays 0.
- R4: cfg_bl8=1 selects 8-beat bursts (4 clocks); cfg_bl8=0 selects 4-beat bursts (2 clocks). The beat output counts 0, 1, ... across the clocks of a window.
- R5: In sequential mode (cfg_ilv=0) with start column c and beat i (even beat 2*beat, odd beat 2*beat+1), the offset is {c[2], (c[1:0]+i) mod 4} for 4-beat bursts and {c[2] xor i[2], (c[1:0]+i) mod 4} for 8-beat bursts.
- R6: In interleaved mode (cfg_ilv=1) the offset of beat i is c[2:0] xor i.
- R7: A command that arrives fewer than max(2, burst-length/2) clocks after the last accepted command raises proto_err in the next clock and opens no window.
- R8: Commands spaced exactly at the minimum are both scheduled, and their windows follow each other without a gap.
- R9: A configuration write is ignored while any burst is outstanding or while a command is being presented in the same clock.
- R10: A configuration write with column latency outside 3..5 or additive latency above 4 is ignored as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Column command present this clock |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 10 | Start column of the command |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cl | input | 3 | Column-access latency in clocks |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts, 0 = 4-beat bursts |
| cfg_ilv | input | 1 | 1 = interleaved beat order, 0 = sequential |
| rd_valid | output | 1 | Read data expected this clock |
| rd_beat | output | 2 | Clock index within the read burst |
| rd_col_e | output | 3 | Column offset of the even read beat |
| rd_col_o | output | 3 | Column offset of the odd read beat |
| wr_valid | output | 1 | Write data and strobes to be driven this clock |
| wr_beat | output | 2 | Clock index within the write burst |
| wr_col_e | output | 3 | Column offset of the even write beat |
| wr_col_o | output | 3 | Column offset of the odd write beat |
| proto_err | output | 1 | Pulse: a command was dropped for spacing |

## Verification
The bench follows each burst cycle by cycle against a window computed from the programmed latencies, so an off-by-one in the additive sum or in the one-clock write reduction shows up as a window that is early or late. Sequential 8-beat bursts from an odd start column, and a 4-beat burst that wraps from column 7, catch an ordering that carries into bit 2 or forgets to flip it. Commands two clocks apart are sent in both burst lengths: a wrong spacing rule either drops a legal back-to-back pair or lets two 8-beat windows overlap. Configuration writes that arrive during a burst, together with a command, or with illegal values must leave the read latency unchanged, so a design that updates its latency at the wrong time moves the next window.

// File: rtl/cls_pkg.sv
package cls_pkg;

  localparam int MIN_CL = 3;
  localparam int MAX_CL = 5;
  localparam int MAX_AL = 4;

  typedef struct packed {
    logic [2:0] cl;
    logic [2:0] al;
    logic       bl8;
    logic       ilv;
  } cfg_t;

  // Column offset of beat number beat within a burst starting at column start.
  function automatic logic [2:0] burst_col(input logic [2:0] start,
                                           input logic [2:0] beat,
                                           input logic       bl8,
                                           input logic       ilv);
    logic [1:0] low;
    low = start[1:0] + beat[1:0];
    if (ilv)      return start ^ beat;
    else if (bl8) return {start[2] ^ beat[2], low};
    else          return {start[2], low};
  endfunction

endpackage

// File: rtl/cls_cfg.sv
module cls_cfg
  import cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       hold,
  input  logic [2:0] cl,
  input  logic [2:0] al,
  input  logic       bl8,
  input  logic       ilv,
  output cfg_t       cfg_q
);

  cfg_t cfg_d;
  logic legal;

  always_comb begin
    legal = (int'(cl) >= MIN_CL) && (int'(cl) <= MAX_CL) && (int'(al) <= MAX_AL);
    cfg_d = cfg_q;
    if (we && !hold && legal) begin
      cfg_d.cl  = cl;
      cfg_d.al  = al;
      cfg_d.bl8 = bl8;
      cfg_d.ilv = ilv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.cl  <= 3'(MIN_CL);
      cfg_q.al  <= 3'd0;
      cfg_q.bl8 <= 1'b0;
      cfg_q.ilv <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/cls_gate.sv
module cls_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] burst_clks,
  input  logic       free_any,
  output logic       accept,
  output logic       err_q
);

  logic [2:0] since_q, since_d;
  logic       err_d;
  logic       spaced;

  always_comb begin
    spaced  = since_q >= (burst_clks - 3'd1);
    accept  = cmd_valid && spaced && free_any;
    err_d   = cmd_valid && !accept;
    since_d = since_q;
    if (accept)               since_d = 3'd0;
    else if (since_q != 3'd7) since_d = since_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 3'd7;
      err_q   <= 1'b0;
    end else begin
      since_q <= since_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/cls_slot.sv
module cls_slot
  import cls_pkg::*;
#(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ld_wr,
  input  logic [2:0]       ld_col,
  input  logic [AGE_W-1:0] rl,
  input  logic [2:0]       burst_clks,
  input  logic             bl8,
  input  logic             ilv,
  output logic             busy,
  output logic             rd_act,
  output logic             wr_act,
  output logic [1:0]       beat,
  output logic [2:0]       col_e,
  output logic [2:0]       col_o
);

  logic             busy_d, wr_q, wr_d;
  logic [2:0]       col_q, col_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [AGE_W-1:0] start, stop, rel;
  logic             act, last;

  always_comb begin
    start = wr_q ? (rl - AGE_W'(1)) : rl;
    stop  = start + AGE_W'(burst_clks);
    rel   = age_q - start;
    act   = busy && (age_q >= start) && (age_q < stop);
    last  = busy && (age_q == stop - AGE_W'(1));
    rd_act = act && !wr_q;
    wr_act = act && wr_q;
    beat   = act ? rel[1:0] : 2'd0;
    col_e  = act ? burst_col(col_q, {rel[1:0], 1'b0}, bl8, ilv) : 3'd0;
    col_o  = act ? burst_col(col_q, {rel[1:0], 1'b1}, bl8, ilv) : 3'd0;

    busy_d = busy;
    wr_d   = wr_q;
    col_d  = col_q;
    age_d  = age_q;
    if (load) begin
      busy_d = 1'b1;
      wr_d   = ld_wr;
      col_d  = ld_col;
      age_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy) begin
      age_d  = age_q + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wr_q  <= 1'b0;
      col_q <= 3'd0;
      age_q <= '0;
    end else begin
      busy  <= busy_d;
      wr_q  <= wr_d;
      col_q <= col_d;
      age_q <= age_d;
    end
  end

endmodule

// File: rtl/cas_lat_seq.sv
module cas_lat_seq
  import cls_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_cl,
  input  logic [2:0]       cfg_al,
  input  logic             cfg_bl8,
  input  logic             cfg_ilv,
  output logic             rd_valid,
  output logic [1:0]       rd_beat,
  output logic [2:0]       rd_col_e,
  output logic [2:0]       rd_col_o,
  output logic             wr_valid,
  output logic [1:0]       wr_beat,
  output logic [2:0]       wr_col_e,
  output logic [2:0]       wr_col_o,
  output logic             proto_err
);

  localparam int AGE_W = $clog2(MAX_AL + MAX_CL + 4 + 1);

  cfg_t             cfg_q;
  logic [AGE_W-1:0] rl;
  logic [2:0]       burst_clks;
  logic             accept, free_any, busy_any, any_load;
  logic [SLOTS-1:0] s_busy, s_rd, s_wr, load;
  logic [1:0]       s_beat [SLOTS];
  logic [2:0]       s_ce   [SLOTS];
  logic [2:0]       s_co   [SLOTS];
  logic             unused_col_hi;

  assign unused_col_hi = ^cmd_col[COL_W-1:3];
  assign rl         = AGE_W'(cfg_q.al) + AGE_W'(cfg_q.cl);
  assign burst_clks = cfg_q.bl8 ? 3'd4 : 3'd2;
  assign free_any   = ~&s_busy;
  assign busy_any   = (|s_busy) | cmd_valid;
  assign any_load   = |load;

  cls_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .hold(busy_any),
    .cl(cfg_cl), .al(cfg_al), .bl8(cfg_bl8), .ilv(cfg_ilv), .cfg_q(cfg_q)
  );

  cls_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .burst_clks(burst_clks),
    .free_any(free_any), .accept(accept), .err_q(proto_err)
  );

  // Lowest free slot takes the accepted command.
  always_comb begin
    logic found;
    found = 1'b0;
    load  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (accept && !found && !s_busy[i]) begin
        load[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    cls_slot #(.AGE_W(AGE_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(load[g]), .ld_wr(cmd_wr),
      .ld_col(cmd_col[2:0]), .rl(rl), .burst_clks(burst_clks),
      .bl8(cfg_q.bl8), .ilv(cfg_q.ilv), .busy(s_busy[g]),
      .rd_act(s_rd[g]), .wr_act(s_wr[g]), .beat(s_beat[g]),
      .col_e(s_ce[g]), .col_o(s_co[g])
    );
  end

  always_comb begin
    rd_beat  = 2'd0;
    rd_col_e = 3'd0;
    rd_col_o = 3'd0;
    wr_beat  = 2'd0;
    wr_col_e = 3'd0;
    wr_col_o = 3'd0;
    for (int i = 0; i < SLOTS; i++) begin
      if (s_rd[i]) begin
        rd_beat  = rd_beat  | s_beat[i];
        rd_col_e = rd_col_e | s_ce[i];
        rd_col_o = rd_col_o | s_co[i];
      end
      if (s_wr[i]) begin
        wr_beat  = wr_beat  | s_beat[i];
        wr_col_e = wr_col_e | s_ce[i];
        wr_col_o = wr_col_o | s_co[i];
      end
    end
    rd_valid = |s_rd;
    wr_valid = |s_wr;
  end

endmodule

// File: rtl/cls_chk.sv
module cls_chk
  import cls_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic [1:0]       rd_beat,
  input logic             wr_valid,
  input logic [1:0]       wr_beat,
  input logic             proto_err,
  input logic [SLOTS-1:0] s_rd,
  input logic [SLOTS-1:0] s_wr,
  input logic             any_load,
  input logic             busy_any,
  input cfg_t             cfg
);

  logic [1:0] last_beat;
  assign last_beat = cfg.bl8 ? 2'd3 : 2'd1;

  // R8: one read burst and one write burst on the bus at a time.
  assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_rd));
  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_wr));

  // R4: a window steps its beat index until the last clock of the burst.
  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != last_beat) |=> (rd_valid && rd_beat == $past(rd_beat) + 2'd1));
  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_beat != last_beat) |=> (wr_valid && wr_beat == $past(wr_beat) + 2'd1));

  // R7: a flagged command never occupied a slot.
  assert_err_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !$past(any_load));

  // R9: configuration holds while work is outstanding.
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |=> $stable(cfg));

  // R10: the held configuration is always a legal one.
  assert_cfg_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg.cl) >= MIN_CL) && (int'(cfg.cl) <= MAX_CL) && (int'(cfg.al) <= MAX_AL));

endmodule

bind cas_lat_seq cls_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_beat(rd_beat),
  .wr_valid(wr_valid), .wr_beat(wr_beat), .proto_err(proto_err),
  .s_rd(s_rd), .s_wr(s_wr), .any_load(any_load), .busy_any(busy_any),
  .cfg(cfg_q)
);

// File: tb/cas_lat_seq_tb.sv
module cas_lat_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_wr, cfg_we, cfg_bl8, cfg_ilv;
  logic [9:0] cmd_col;
  logic [2:0] cfg_cl, cfg_al;
  logic       rd_valid, wr_valid, proto_err;
  logic [1:0] rd_beat, wr_beat;
  logic [2:0] rd_col_e, rd_col_o, wr_col_e, wr_col_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cas_lat_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_col(cmd_col), .cfg_we(cfg_we), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cfg_ilv(cfg_ilv), .rd_valid(rd_valid),
    .rd_beat(rd_beat), .rd_col_e(rd_col_e), .rd_col_o(rd_col_o),
    .wr_valid(wr_valid), .wr_beat(wr_beat), .wr_col_e(wr_col_e),
    .wr_col_o(wr_col_o), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int c, input int i, input bit bl8, input bit ilv);
    int c3;
    c3 = c & 7;
    if (ilv) return c3 ^ i;
    if (bl8) return ((c3 + i) & 3) | ((c3 ^ i) & 4);
    return (c3 & 4) | ((c3 + i) & 3);
  endfunction

  task automatic set_cfg(input int cl, input int al, input bit bl8, input bit ilv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = bl8; cfg_ilv = ilv;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one command and follow its window clock by clock.
  task automatic run_cmd(input bit wr, input int col, input int rl, input bit bl8,
                         input bit ilv, input string req);
    int half, st, b;
    bit act;
    logic v, ov;
    logic [1:0] bt;
    logic [2:0] ce, co;
    half = bl8 ? 4 : 2;
    st   = wr ? rl - 1 : rl;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = wr; cmd_col = 10'(col);
    @(posedge clk);
    for (int k = 0; k < st + half + 2; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      act = (k >= st) && (k < st + half);
      v  = wr ? wr_valid : rd_valid;
      ov = wr ? rd_valid : wr_valid;
      bt = wr ? wr_beat  : rd_beat;
      ce = wr ? wr_col_e : rd_col_e;
      co = wr ? wr_col_o : rd_col_o;
      chk(v == act, req, int'(v), int'(act));
      chk(ov == 1'b0, req, int'(ov), 0);
      if (act) begin
        b = k - st;
        chk(int'(bt) == b, req, int'(bt), b);
        chk(int'(ce) == exp_col(col, 2 * b, bl8, ilv), req, int'(ce), exp_col(col, 2 * b, bl8, ilv));
        chk(int'(co) == exp_col(col, 2 * b + 1, bl8, ilv), req, int'(co), exp_col(col, 2 * b + 1, bl8, ilv));
      end
    end
  endtask

  // R7 (bl8) and R8 (bl4): second read two clocks after the first.
  task automatic t_spacing(input bit bl8);
    string req;
    int b, c;
    bit act, e;
    req = bl8 ? "R7" : "R8";
    set_cfg(3, 0, bl8, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 10'd1;
    @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (k == 1) begin cmd_valid = 1'b1; cmd_col = 10'd6; end
      if (k == 2) cmd_valid = 1'b0;
      e   = bl8 && (k == 2);
      act = (k >= 3) && (k < 7);
      chk(proto_err == e, req, int'(proto_err), int'(e));
      chk(rd_valid == act, req, int'(rd_valid), int'(act));
      if (act) begin
        b = bl8 ? k - 3 : (k - 3) % 2;
        c = (bl8 || k < 5) ? 1 : 6;
        chk(int'(rd_beat) == b, req, int'(rd_beat), b);
        chk(int'(rd_col_e) == exp_col(c, 2 * b, bl8, 1'b0), req, int'(rd_col_e), exp_col(c, 2 * b, bl8, 1'b0));
      end
    end
  endtask

  // R9: configuration writes during a burst or with a command are dropped.
  task automatic t_cfg_busy();
    set_cfg(3, 0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 10'd0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (k == 1) begin cfg_we = 1'b1; cfg_cl = 3'd5; cfg_al = 3'd2; end
      if (k == 2) cfg_we = 1'b0;
    end
    run_cmd(1'b0, 2, 3, 1'b0, 1'b0, "R9");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 10'd0;
    cfg_we = 1'b1; cfg_cl = 3'd4; cfg_al = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0;
    repeat (8) @(negedge clk);
    run_cmd(1'b0, 1, 3, 1'b0, 1'b0, "R9");
    set_cfg(4, 0, 1'b0, 1'b0);
    run_cmd(1'b0, 1, 4, 1'b0, 1'b0, "R9");
  endtask

  // R10: illegal latency values leave the configuration unchanged.
  task automatic t_cfg_bad();
    set_cfg(4, 1, 1'b0, 1'b0);
    set_cfg(6, 0, 1'b0, 1'b0);
    run_cmd(1'b0, 3, 5, 1'b0, 1'b0, "R10");
    set_cfg(2, 0, 1'b0, 1'b0);
    run_cmd(1'b0, 3, 5, 1'b0, 1'b0, "R10");
    set_cfg(3, 5, 1'b0, 1'b0);
    run_cmd(1'b0, 3, 5, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_wr = 1'b0; cmd_col = '0;
    cfg_we = 1'b0; cfg_cl = '0; cfg_al = '0; cfg_bl8 = 1'b0; cfg_ilv = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !wr_valid && !proto_err, "R1", int'(rd_valid | wr_valid | proto_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_valid && !wr_valid && !proto_err, "R1", int'(rd_valid | wr_valid | proto_err), 0);
    run_cmd(1'b0, 5, 3, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    t_reset();
    set_cfg(4, 2, 1'b0, 1'b0);
    run_cmd(1'b0, 3, 6, 1'b0, 1'b0, "R2");
    run_cmd(1'b1, 3, 6, 1'b0, 1'b0, "R3");
    set_cfg(5, 4, 1'b1, 1'b0);
    run_cmd(1'b0, 5, 9, 1'b1, 1'b0, "R5");
    run_cmd(1'b1, 46, 9, 1'b1, 1'b0, "R4");
    set_cfg(3, 3, 1'b0, 1'b0);
    run_cmd(1'b0, 7, 6, 1'b0, 1'b0, "R5");
    set_cfg(3, 1, 1'b1, 1'b1);
    run_cmd(1'b0, 3, 4, 1'b1, 1'b1, "R6");
    set_cfg(5, 0, 1'b0, 1'b1);
    run_cmd(1'b1, 6, 5, 1'b0, 1'b1, "R6");
    t_spacing(1'b1);
    t_spacing(1'b0);
    t_cfg_busy();
    t_cfg_bad();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule